// File: doc/BRIEF.md
# Emulation Mode Entry Detector

This block watches three chip pins (the reset pin, the address-latch strobe and the program-store strobe) to find the pin sequence that puts a microcontroller into on-circuit emulation mode. It does not use a register write. The mode is requested when the address-latch strobe is held low and the program-store strobe is held high while reset is active, and the address-latch strobe is still low when reset is let go. The decision is made once, at the reset release.

While the mode is active, the block drives the pad controls for the chip's pins:

- The Port 0 output drivers are turned off, so those pins float.
- The strong drivers of the other ports and of both strobe pins are turned off, and their weak pull-ups are turned on.
- The oscillator enable is held on, whatever the core requests.

The mode ends only at a later reset whose release sees the address-latch strobe high. All three pin inputs pass through a two-flop synchronizer before they are evaluated. A separate power-on reset input puts the block's own flops into a known state.

Top module: `emu_mode_detect`

## Requirements
- R1: After the power-on reset `por_n` is released, `emu_active` is 0, and the pad controls follow the normal-operation mapping of R6, R7 and R8.
- R2: The mode is entered when two conditions hold. First, on every synchronized cycle in which the reset pin is high (1), the address-latch strobe is low and the program-store strobe is high. Second, the address-latch strobe is low on the cycle in which the synchronized reset is seen low again. `emu_active` becomes 1 at the third rising clock edge that samples the released reset pin.
- R3: A single synchronized reset cycle with the address-latch strobe high, or with the program-store strobe low, prevents entry at that reset's release.
- R4: If the address-latch strobe is high on the release cycle, the reset is a normal reset. `emu_active` is then 0 from the same edge given in R2, and this applies even if the mode was active before. This includes the case where the strobe rises in the same cycle that reset falls.
- R5: The mode state does not change while reset is held, and it does not change while reset stays low, whatever the strobe pins do.
- R6: `p0_oe` equals `core_p0_oe` outside the mode and is all zeros (Port 0 floats) in the mode.
- R7: In the mode, every bit of `port_drive_en` is 0 and every bit of `port_weak_pu` is 1, with `strobe_drive_en`=0 and `strobe_weak_pu`=1. Outside the mode, all of these take the opposite values.
- R8: `osc_en` is 1 in the mode and equals `core_osc_req` outside it.
- R9: `emu_active` is 1 exactly while the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset for the block's own flops, active low, asynchronous |
| rst_pin | input | 1 | Chip reset pin as seen at the pad, active high |
| ale_pin | input | 1 | Address-latch strobe pin level |
| psen_pin | input | 1 | Program-store strobe pin level |
| core_p0_oe | input | P0_W | Port 0 output enables requested by the core |
| core_osc_req | input | 1 | Oscillator enable requested by the core |
| emu_active | output | 1 | High while emulation mode is active |
| p0_oe | output | P0_W | Port 0 output enables delivered to the pads |
| port_drive_en | output | NUM_PORTS | Strong-driver enable for each of the other ports |
| port_weak_pu | output | NUM_PORTS | Weak pull-up enable for each of the other ports |
| strobe_drive_en | output | 1 | Strong-driver enable for the two strobe pins |
| strobe_weak_pu | output | 1 | Weak pull-up enable for the two strobe pins |
| osc_en | output | 1 | Oscillator enable |

## Verification
Two events can fall on the same cycle. The reset release can coincide with a change on the address-latch strobe, and the mode decision can coincide with a change in the core's oscillator or Port 0 requests.

The bench provokes the first case in two ways. It raises the strobe in the same cycle that reset drops, which must give a normal reset. It also raises the strobe one cycle later, which must give entry.

For the second case, the bench toggles the core requests while reset is being released. A behavioural model, fed from a queue of delayed pin samples, judges every output on every clock. Explicit checks then pin down the exact edge on which the mode changes.

// File: rtl/emu_pkg.sv
package emu_pkg;

  typedef struct packed {
    logic rst;
    logic ale;
    logic psen;
  } pin_t;

  // Pin levels on one reset cycle that keep the entry request alive.
  function automatic logic cycle_qualifies(input logic ale, input logic psen);
    return (~ale) & psen;
  endfunction

  // Candidate flag after one cycle of reset; the first cycle starts from 1.
  function automatic logic next_candidate(input logic first, input logic cand,
                                          input logic ale, input logic psen);
    return (first | cand) & cycle_qualifies(ale, psen);
  endfunction

  // Decision taken on the release cycle.
  function automatic logic release_decision(input logic cand, input logic ale);
    return cand & ~ale;
  endfunction

  // Port 0 enable mask while the mode is active.
  function automatic logic gate_enable(input logic core_oe, input logic emu);
    return core_oe & ~emu;
  endfunction

endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/emu_detect.sv
module emu_detect
  import emu_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  pin_t pins_s,
  output logic emu,
  output logic cand,
  output logic rel_evt
);
  logic rst_d;
  logic first_evt;

  assign rel_evt   = rst_d & ~pins_s.rst;
  assign first_evt = pins_s.rst & ~rst_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_d <= 1'b0;
      cand  <= 1'b0;
      emu   <= 1'b0;
    end else begin
      rst_d <= pins_s.rst;
      if (pins_s.rst)
        cand <= next_candidate(first_evt, cand, pins_s.ale, pins_s.psen);
      else
        cand <= 1'b0;
      if (rel_evt)
        emu <= release_decision(cand, pins_s.ale);
    end
  end

  // R5: mode frozen while reset is held
  a_r5_hold_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    pins_s.rst |=> $stable(emu));

  // R5: mode frozen while reset stays low
  a_r5_hold_in_run: assert property (@(posedge clk) disable iff (!por_n)
    (!pins_s.rst && !rst_d) |=> $stable(emu));

  // R3: a disqualifying reset cycle kills the candidate
  a_r3_cand_cleared: assert property (@(posedge clk) disable iff (!por_n)
    (pins_s.rst && (pins_s.ale || !pins_s.psen)) |=> !cand);

  // R2: entry only on a release with the strobe low
  a_r2_entry_on_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(emu) |-> ($past(rel_evt) && !$past(pins_s.ale)));

  // R4: release with the strobe high leaves the mode off
  a_r4_normal_release: assert property (@(posedge clk) disable iff (!por_n)
    (rel_evt && pins_s.ale) |=> !emu);
endmodule

// File: rtl/emu_pad.sv
module emu_pad
  import emu_pkg::*;
#(
  parameter int P0_W      = 8,
  parameter int NUM_PORTS = 3
) (
  input  logic                 emu,
  input  logic [P0_W-1:0]      core_p0_oe,
  input  logic                 core_osc_req,
  output logic [P0_W-1:0]      p0_oe,
  output logic [NUM_PORTS-1:0] port_drive_en,
  output logic [NUM_PORTS-1:0] port_weak_pu,
  output logic                 strobe_drive_en,
  output logic                 strobe_weak_pu,
  output logic                 osc_en
);
  for (genvar b = 0; b < P0_W; b++) begin : g_p0
    assign p0_oe[b] = gate_enable(core_p0_oe[b], emu);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_drive_en[p] = ~emu;
    assign port_weak_pu[p]  = emu;
  end

  assign strobe_drive_en = ~emu;
  assign strobe_weak_pu  = emu;
  assign osc_en          = core_osc_req | emu;
endmodule

// File: rtl/emu_mode_detect.sv
module emu_mode_detect
  import emu_pkg::*;
#(
  parameter int P0_W      = 8,
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_pin,
  input  logic                 ale_pin,
  input  logic                 psen_pin,
  input  logic [P0_W-1:0]      core_p0_oe,
  input  logic                 core_osc_req,
  output logic                 emu_active,
  output logic [P0_W-1:0]      p0_oe,
  output logic [NUM_PORTS-1:0] port_drive_en,
  output logic [NUM_PORTS-1:0] port_weak_pu,
  output logic                 strobe_drive_en,
  output logic                 strobe_weak_pu,
  output logic                 osc_en
);
  localparam int PIN_W = $bits(pin_t);

  pin_t pins_raw;
  pin_t pins_s;
  logic emu;
  logic cand;
  logic rel_evt;

  assign pins_raw = '{rst: rst_pin, ale: ale_pin, psen: psen_pin};

  emu_sync #(.W(PIN_W)) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  emu_detect u_detect (
    .clk    (clk),
    .por_n  (por_n),
    .pins_s (pins_s),
    .emu    (emu),
    .cand   (cand),
    .rel_evt(rel_evt)
  );

  emu_pad #(.P0_W(P0_W), .NUM_PORTS(NUM_PORTS)) u_pad (
    .emu            (emu),
    .core_p0_oe     (core_p0_oe),
    .core_osc_req   (core_osc_req),
    .p0_oe          (p0_oe),
    .port_drive_en  (port_drive_en),
    .port_weak_pu   (port_weak_pu),
    .strobe_drive_en(strobe_drive_en),
    .strobe_weak_pu (strobe_weak_pu),
    .osc_en         (osc_en)
  );

  assign emu_active = emu;

  // R6: Port 0 floats in the mode
  a_r6_p0_float: assert property (@(posedge clk) disable iff (!por_n)
    emu_active |-> (p0_oe == '0));

  // R7: weak pull-ups only in the mode
  a_r7_weak_pulls: assert property (@(posedge clk) disable iff (!por_n)
    emu_active |-> ((&port_weak_pu) && !(|port_drive_en) && strobe_weak_pu && !strobe_drive_en));

  // R8: oscillator kept running in the mode
  a_r8_osc_on: assert property (@(posedge clk) disable iff (!por_n)
    emu_active |-> osc_en);

  // R7: drivers back on outside the mode
  a_r7_normal_drive: assert property (@(posedge clk) disable iff (!por_n)
    !emu_active |-> ((&port_drive_en) && !(|port_weak_pu) && strobe_drive_en));
endmodule

// File: tb/emu_mode_detect_test.sv
module emu_mode_detect_test;
  localparam int P0_W = 8;
  localparam int NP   = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, ale_pin = 1'b1, psen_pin = 1'b1;
  logic [P0_W-1:0] core_p0_oe = '0;
  logic core_osc_req = 1'b1;
  logic emu_active;
  logic [P0_W-1:0] p0_oe;
  logic [NP-1:0] port_drive_en, port_weak_pu;
  logic strobe_drive_en, strobe_weak_pu, osc_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  emu_mode_detect #(.P0_W(P0_W), .NUM_PORTS(NP)) uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ale_pin(ale_pin),
    .psen_pin(psen_pin), .core_p0_oe(core_p0_oe), .core_osc_req(core_osc_req),
    .emu_active(emu_active), .p0_oe(p0_oe), .port_drive_en(port_drive_en),
    .port_weak_pu(port_weak_pu), .strobe_drive_en(strobe_drive_en),
    .strobe_weak_pu(strobe_weak_pu), .osc_en(osc_en)
  );

  // Behavioural model: pin samples delayed through a queue, a "spoiled" flag.
  typedef struct { bit r; bit a; bit p; } samp_t;
  samp_t hist[$];
  bit m_mode = 0, m_spoiled = 0, m_in_rst = 0;

  task automatic model_clear();
    samp_t z;
    z.r = 0; z.a = 0; z.p = 0;
    hist = {};
    hist.push_back(z);
    hist.push_back(z);
    m_mode = 0; m_spoiled = 0; m_in_rst = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      model_clear();
    end else begin
      samp_t now, old;
      now.r = rst_pin; now.a = ale_pin; now.p = psen_pin;
      old = hist[0];
      if (m_in_rst && !old.r) m_mode = !m_spoiled && !old.a;
      if (old.r) begin
        if (!m_in_rst) m_spoiled = 0;
        if (old.a || !old.p) m_spoiled = 1;
      end
      m_in_rst = old.r;
      hist.push_back(now);
      void'(hist.pop_front());
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output with the model on every clock.
  always @(negedge clk) begin
    if (por_n && !done) begin
      chk("R9", "emu_active", emu_active, m_mode);
      chk("R6", "p0_oe", p0_oe, m_mode ? 0 : core_p0_oe);
      chk("R7", "port_drive_en", port_drive_en, m_mode ? 0 : {NP{1'b1}});
      chk("R7", "port_weak_pu", port_weak_pu, m_mode ? {NP{1'b1}} : 0);
      chk("R7", "strobe_drive_en", strobe_drive_en, !m_mode);
      chk("R7", "strobe_weak_pu", strobe_weak_pu, m_mode);
      chk("R8", "osc_en", osc_en, m_mode | core_osc_req);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Reset window of n cycles, then release with the given strobe level.
  task automatic reset_window(int n, bit ale_lvl, bit psen_lvl, bit ale_at_rel);
    rst_pin = 1; ale_pin = ale_lvl; psen_pin = psen_lvl;
    cyc(n);
    rst_pin = 0; ale_pin = ale_at_rel;
  endtask

  initial begin
    cyc(3);
    por_n = 1;
    cyc(2);
    chk("R1", "emu after por", emu_active, 0);
    chk("R1", "p0 passthrough", p0_oe, 8'h00);
    core_p0_oe = 8'hA5;
    cyc(1);
    chk("R6", "p0 normal", p0_oe, 8'hA5);

    // Normal reset, ALE high throughout
    reset_window(6, 1, 1, 1);
    cyc(5);
    chk("R4", "normal reset", emu_active, 0);

    // Entry, with exact latency
    reset_window(6, 0, 1, 0);
    cyc(2);
    chk("R2", "not yet after 2 edges", emu_active, 0);
    cyc(1);
    chk("R2", "entered at 3rd edge", emu_active, 1);
    chk("R6", "p0 floats", p0_oe, 0);
    chk("R8", "osc kept", osc_en, 1);

    // Strobes wiggle out of reset: no effect
    core_osc_req = 0; core_p0_oe = 8'h3C;
    for (int i = 0; i < 8; i++) begin
      ale_pin = i[0]; psen_pin = i[1];
      cyc(1);
    end
    chk("R5", "held in run", emu_active, 1);
    chk("R8", "osc forced", osc_en, 1);

    // Reset with ALE high: held during reset, exits at release
    reset_window(5, 1, 1, 1);
    chk("R5", "held in reset", emu_active, 1);
    cyc(2);
    chk("R4", "still on 2 edges after release", emu_active, 1);
    cyc(1);
    chk("R4", "exit at 3rd edge", emu_active, 0);
    chk("R8", "osc follows core", osc_en, 0);
    chk("R6", "p0 restored", p0_oe, 8'h3C);

    // One PSEN-low cycle spoils entry
    rst_pin = 1; ale_pin = 0; psen_pin = 1; cyc(3);
    psen_pin = 0; cyc(1);
    psen_pin = 1; cyc(3);
    rst_pin = 0; cyc(5);
    chk("R3", "psen glitch blocks", emu_active, 0);

    // One ALE-high cycle spoils entry
    rst_pin = 1; ale_pin = 0; cyc(3);
    ale_pin = 1; cyc(1);
    ale_pin = 0; cyc(3);
    rst_pin = 0; cyc(5);
    chk("R3", "ale glitch blocks", emu_active, 0);

    // ALE rises in the same cycle reset falls: normal reset
    core_osc_req = 1;
    reset_window(4, 0, 1, 1);
    core_p0_oe = 8'hFF;
    cyc(5);
    chk("R4", "same-cycle ale rise", emu_active, 0);

    // ALE rises one cycle after release: entry
    reset_window(4, 0, 1, 0);
    core_osc_req = 0;
    cyc(1);
    ale_pin = 1;
    cyc(4);
    chk("R2", "late ale rise enters", emu_active, 1);

    // Qualifying reset while in mode keeps it
    reset_window(4, 0, 1, 0);
    cyc(5);
    chk("R2", "re-entry keeps mode", emu_active, 1);
    chk("R7", "weak pulls", port_weak_pu, {NP{1'b1}});

    // One-cycle reset with strobes correct
    reset_window(1, 1, 1, 1);
    cyc(5);
    chk("R4", "short normal reset", emu_active, 0);
    reset_window(1, 0, 1, 0);
    cyc(5);
    chk("R2", "short entry reset", emu_active, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule